// File: doc/BRIEF.md
# Programmable Four-State Trace Sequencer

This block decides, cycle by cycle, whether a trace stream should be captured. It watches a vector of single-cycle event inputs and steps a four-state machine forward or backward between neighbouring states. Software picks the event behind each of the six transitions through a small write-only configuration port. It also picks what each state does: hold trace capture on, emit a one-cycle marker when the machine arrives there, or both.

A typical use arms capture in stages. One event moves the machine from idle to an armed state, a second turns capture on, and a third drops it back. Because the transitions run between neighbours only, each state has at most one way up and one way down. The block reports its current state, a trace-enable level and a log strobe.

Top module: `trace_seq_top`

## Requirements
- R1: After reset the state is 0, trace_en is 0 and log_pulse is 0. All configuration is cleared, so no event moves the machine until a transition is enabled.
- R2: Config addresses 0, 1 and 2 hold the up-transitions out of states 0, 1 and 2. Write data bit EVW (bit 4 by default) enables the transition and bits [EVW-1:0] select the event index. When the machine sits in state n below 3 and the selected event is high while enabled, the state reads n+1 after the next clock edge.
- R3: Config addresses 3, 4 and 5 hold the down-transitions into states 0, 1 and 2, using the same field layout as R2. When the machine sits in state n+1 and the selected event is high while enabled, the state reads n after the next clock edge.
- R4: A transition whose enable bit is 0 never fires, whatever its event does.
- R5: If the up and down conditions of the current state are both true in one cycle, the machine moves up.
- R6: The state moves by at most one step per clock. No up-transition leaves state 3 and no down-transition leaves state 0.
- R7: Config addresses 6 to 9 hold the actions of states 0 to 3. Bit 0 is the trace action, and trace_en equals the trace bit of the current state.
- R8: Bit 1 of a state's action word is its log action. log_pulse is high for exactly the cycle in which the state output first shows an entered state whose log bit is set. It stays low while the state is held and on entry to a state whose log bit is clear.
- R9: A configuration write is used from the cycle after its clock edge. An event in the same cycle as the write is judged against the old setting. A write never changes the current state by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| events | input | NUM_EVENTS | Single-cycle event inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration register address |
| cfg_wdata | input | EVW+1 | Configuration write data |
| state | output | 2 | Current sequencer state |
| trace_en | output | 1 | Trace capture enable level |
| log_pulse | output | 1 | One-cycle marker on entry to a logging state |

## Verification
The assertions assume that events and configuration inputs change only between clock edges and that reset is applied before any write. They also assume that event indices name existing inputs. The bench drives every input on the falling edge, writes only defined addresses, and uses event indices below NUM_EVENTS. Because of this, each rising edge sees one settled set of conditions.

// File: rtl/trseq_pkg.sv
package trseq_pkg;

    localparam int NSTATES = 4;
    localparam int NTRANS  = 3;

    typedef logic [1:0] seq_state_t;

    typedef struct packed {
        seq_state_t state;
        logic       log_mark;
    } fsm_reg_t;

endpackage

// File: rtl/trseq_cfg_regs.sv
module trseq_cfg_regs
    import trseq_pkg::*;
#(
    parameter int EVW    = 4,
    parameter int ADDR_W = 4,
    localparam int DW    = EVW + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [DW-1:0]               cfg_wdata,
    output logic [NTRANS-1:0]           up_en,
    output logic [NTRANS-1:0][EVW-1:0]  up_idx,
    output logic [NTRANS-1:0]           dn_en,
    output logic [NTRANS-1:0][EVW-1:0]  dn_idx,
    output logic [NSTATES-1:0]          act_trace,
    output logic [NSTATES-1:0]          act_log
);

    localparam int UP_BASE  = 0;
    localparam int DN_BASE  = UP_BASE + NTRANS;
    localparam int ACT_BASE = DN_BASE + NTRANS;

    typedef struct packed {
        logic [NTRANS-1:0]          ue;
        logic [NTRANS-1:0][EVW-1:0] ui;
        logic [NTRANS-1:0]          de;
        logic [NTRANS-1:0][EVW-1:0] di;
        logic [NSTATES-1:0]         tr;
        logic [NSTATES-1:0]         lg;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int k = 0; k < NTRANS; k++) begin
                if (cfg_addr == ADDR_W'(UP_BASE + k)) begin
                    cfg_d.ue[k] = cfg_wdata[EVW];
                    cfg_d.ui[k] = cfg_wdata[EVW-1:0];
                end
                if (cfg_addr == ADDR_W'(DN_BASE + k)) begin
                    cfg_d.de[k] = cfg_wdata[EVW];
                    cfg_d.di[k] = cfg_wdata[EVW-1:0];
                end
            end
            for (int s = 0; s < NSTATES; s++) begin
                if (cfg_addr == ADDR_W'(ACT_BASE + s)) begin
                    cfg_d.tr[s] = cfg_wdata[0];
                    cfg_d.lg[s] = cfg_wdata[1];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign up_en     = cfg_q.ue;
    assign up_idx    = cfg_q.ui;
    assign dn_en     = cfg_q.de;
    assign dn_idx    = cfg_q.di;
    assign act_trace = cfg_q.tr;
    assign act_log   = cfg_q.lg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/trseq_cond.sv
module trseq_cond
    import trseq_pkg::*;
#(
    parameter int NUM_EVENTS = 16,
    parameter int EVW        = 4
) (
    input  logic [NUM_EVENTS-1:0]       events,
    input  logic [NTRANS-1:0]           up_en,
    input  logic [NTRANS-1:0][EVW-1:0]  up_idx,
    input  logic [NTRANS-1:0]           dn_en,
    input  logic [NTRANS-1:0][EVW-1:0]  dn_idx,
    output logic [NTRANS-1:0]           up_hit,
    output logic [NTRANS-1:0]           dn_hit
);

    for (genvar k = 0; k < NTRANS; k++) begin : g_sel
        always_comb begin
            up_hit[k] = 1'b0;
            dn_hit[k] = 1'b0;
            for (int e = 0; e < NUM_EVENTS; e++) begin
                if (up_en[k] && up_idx[k] == EVW'(e) && events[e]) up_hit[k] = 1'b1;
                if (dn_en[k] && dn_idx[k] == EVW'(e) && events[e]) dn_hit[k] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/trseq_fsm.sv
module trseq_fsm
    import trseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NTRANS-1:0]  up_hit,
    input  logic [NTRANS-1:0]  dn_hit,
    input  logic [NSTATES-1:0] act_trace,
    input  logic [NSTATES-1:0] act_log,
    output seq_state_t         state,
    output logic               trace_en,
    output logic               log_pulse
);

    fsm_reg_t fsm_d, fsm_q;
    logic     go_up, go_dn;

    always_comb begin
        go_up = 1'b0;
        go_dn = 1'b0;
        case (fsm_q.state)
            2'd0: begin go_up = up_hit[0]; go_dn = 1'b0;      end
            2'd1: begin go_up = up_hit[1]; go_dn = dn_hit[0]; end
            2'd2: begin go_up = up_hit[2]; go_dn = dn_hit[1]; end
            default: begin go_up = 1'b0;   go_dn = dn_hit[2]; end
        endcase

        fsm_d          = fsm_q;
        fsm_d.log_mark = 1'b0;
        if (go_up)      fsm_d.state = fsm_q.state + 2'd1;
        else if (go_dn) fsm_d.state = fsm_q.state - 2'd1;
        if (go_up || go_dn) fsm_d.log_mark = act_log[fsm_d.state];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '0;
        else        fsm_q <= fsm_d;
    end

    assign state     = fsm_q.state;
    assign trace_en  = act_trace[fsm_q.state];
    assign log_pulse = fsm_q.log_mark;

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state == $past(state) || state == $past(state) + 2'd1
                  || state + 2'd1 == $past(state))); // R6

    AST_UP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == 2'd0 && up_hit[0]) || (state == 2'd1 && up_hit[1])
         || (state == 2'd2 && up_hit[2]))
        |=> state == $past(state) + 2'd1); // R5

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (up_hit == '0 && dn_hit == '0) |=> $stable(state)); // R4

    AST_LOG_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        log_pulse |-> state != $past(state)); // R8

    AST_TOP_NO_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'd3 && dn_hit[2] == 1'b0) |=> state == 2'd3); // R6

endmodule

// File: rtl/trace_seq_top.sv
module trace_seq_top
    import trseq_pkg::*;
#(
    parameter int NUM_EVENTS = 16,
    parameter int ADDR_W     = 4,
    localparam int EVW       = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  cfg_we,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [EVW:0]          cfg_wdata,
    output logic [1:0]            state,
    output logic                  trace_en,
    output logic                  log_pulse
);

    logic [NTRANS-1:0]          up_en, dn_en, up_hit, dn_hit;
    logic [NTRANS-1:0][EVW-1:0] up_idx, dn_idx;
    logic [NSTATES-1:0]         act_trace, act_log;

    trseq_cfg_regs #(.EVW(EVW), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .up_en(up_en), .up_idx(up_idx),
        .dn_en(dn_en), .dn_idx(dn_idx), .act_trace(act_trace), .act_log(act_log)
    );

    trseq_cond #(.NUM_EVENTS(NUM_EVENTS), .EVW(EVW)) u_cond (
        .events(events), .up_en(up_en), .up_idx(up_idx),
        .dn_en(dn_en), .dn_idx(dn_idx), .up_hit(up_hit), .dn_hit(dn_hit)
    );

    trseq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .up_hit(up_hit), .dn_hit(dn_hit),
        .act_trace(act_trace), .act_log(act_log),
        .state(state), .trace_en(trace_en), .log_pulse(log_pulse)
    );

endmodule

// File: tb/sim_trace_seq_top.sv
module sim_trace_seq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] events = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [4:0]  cfg_wdata = '0;
    logic [1:0]  state;
    logic        trace_en, log_pulse;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trace_seq_top u0 (
        .clk(clk), .rst_n(rst_n), .events(events), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .state(state), .trace_en(trace_en), .log_pulse(log_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [4:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hold(input logic [15:0] m, input int n);
        @(negedge clk);
        events = m;
        for (int i = 0; i < n; i++) @(negedge clk);
        events = '0;
    endtask

    task automatic t_reset();
        check("R1 state", state, 0);
        check("R1 trace_en", trace_en, 0);
        check("R1 log_pulse", log_pulse, 0);
        hold(16'hFFFF, 3);
        check("R1 cleared config, state", state, 0);
    endtask

    task automatic t_forward();
        cfg_write(4'd7, 5'b00011);
        cfg_write(4'd0, 5'h13);
        hold(16'h0008, 1);
        check("R2 up 0->1", state, 1);
        check("R8 log on entry", log_pulse, 1);
        check("R7 trace in state 1", trace_en, 1);
        @(negedge clk);
        check("R8 log one cycle", log_pulse, 0);
        check("R2 state held", state, 1);
    endtask

    task automatic t_backward();
        cfg_write(4'd3, 5'h15);
        hold(16'h0020, 1);
        check("R3 down 1->0", state, 0);
        check("R7 trace off in state 0", trace_en, 0);
        check("R8 no log into state 0", log_pulse, 0);
        hold(16'h0020, 1);
        check("R6 no down from 0", state, 0);
    endtask

    task automatic t_disabled();
        cfg_write(4'd0, 5'h07);
        hold(16'h0080, 2);
        check("R4 disabled up", state, 0);
        hold(16'h0008, 1);
        check("R4 old event gone", state, 0);
    endtask

    task automatic t_priority();
        cfg_write(4'd0, 5'h12);
        hold(16'h0004, 1);
        check("R2 up via new index", state, 1);
        cfg_write(4'd1, 5'h19);
        cfg_write(4'd3, 5'h19);
        hold(16'h0200, 1);
        check("R5 up wins", state, 2);
        check("R8 no log into state 2", log_pulse, 0);
    endtask

    task automatic t_steps();
        cfg_write(4'd3, 5'h11);
        cfg_write(4'd4, 5'h11);
        cfg_write(4'd5, 5'h11);
        hold(16'h0002, 1);
        check("R6 one step down", state, 1);
        hold(16'h0002, 1);
        check("R6 second step down", state, 0);
        cfg_write(4'd3, 5'h00);
        cfg_write(4'd4, 5'h00);
        cfg_write(4'd5, 5'h00);
        cfg_write(4'd0, 5'h11);
        cfg_write(4'd1, 5'h11);
        cfg_write(4'd2, 5'h11);
        cfg_write(4'd9, 5'b00010);
        hold(16'h0002, 1);
        check("R6 one step up", state, 1);
        hold(16'h0002, 2);
        check("R6 reach 3", state, 3);
        check("R8 log into state 3", log_pulse, 1);
        hold(16'h0002, 3);
        check("R6 no up from 3", state, 3);
    endtask

    task automatic t_cfg_timing();
        check("R7 trace off in 3", trace_en, 0);
        cfg_write(4'd9, 5'b00001);
        check("R9 action live next cycle", trace_en, 1);
        check("R9 write keeps state", state, 3);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'd5; cfg_wdata = 5'h1B;
        events = 16'h0800;
        @(negedge clk);
        cfg_we = 1'b0; events = '0;
        check("R9 same-cycle event uses old cfg", state, 3);
        hold(16'h0800, 1);
        check("R3 down 3->2", state, 2);
        check("R7 trace follows state", trace_en, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_forward();
        t_backward();
        t_disabled();
        t_priority();
        t_steps();
        t_cfg_timing();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule